// File: doc/BRIEF.md
# Two-State Write-Through Snooping Cache Controller

This block keeps one small direct-mapped, write-through cache coherent with its peers on a shared bus. Each line holds one word, a tag and a single present bit. A line is either usable or absent. Processor reads that find their word present finish locally. Every other processor access becomes one bus transaction: a read miss fills the line, and a write sends its data through to memory.

The controller also watches the writes that other caches place on the bus. When such a write names a word this cache holds, the local copy is dropped, so the next local read fetches the fresh value. The processor holds each request steady until the controller signals completion, and it issues one operation at a time. The bus is granted to one cache at a time. A granted transaction runs to its acknowledge before any other cache can use the bus, so all writes are ordered by the bus.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset `bus_req`, `bus_valid`, `cpu_busy` and `cpu_done` are low, and every line is absent, so the first read of any address goes to the bus.
- R2: A read of an absent word (or of an index holding a different tag) raises `bus_req`. Once granted, it drives `bus_valid` with `bus_we`=0 and the address. At the acknowledge it stores `bus_rdata` in the line, marks the line present, and returns the same value on `cpu_rdata` with `cpu_done` in the next cycle.
- R3: A read of a present word never raises `bus_req`. `cpu_done` and the stored word appear in the cycle after the lookup edge.
- R4: Every write raises `bus_req` and performs a bus transaction with `bus_we`=1, its address and data. These stay stable from grant to acknowledge, whether or not the word is present.
- R5: A write to a present word leaves it present and replaces the stored word, so a following read completes locally with the new value.
- R6: A write to an absent word does not allocate it, so a following read of that word goes to the bus.
- R7: A snooped write (`snoop_valid`=1, `snoop_we`=1) whose address matches a present line makes that line absent. This holds even while the local processor waits for the bus. A snooped read, or a snooped write with a different tag at the same index, leaves the line present.
- R8: In a cycle with `snoop_valid` high, the processor lookup is not done. A hit that would complete one cycle after the request completes two cycles after it.
- R9: `cpu_busy` and `bus_req` stay high from the lookup that needs the bus until the acknowledge edge. `bus_valid` rises only in the cycle after `bus_gnt` is sampled high.
- R10: `cpu_done` is a one-cycle pulse. The controller ignores `cpu_req` during that cycle and starts no new request in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_busy | output | 1 | A bus transaction for the processor is pending |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` on reads |
| bus_req | output | 1 | Bus request, held through the transaction |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Transaction on the bus |
| bus_we | output | 1 | Transaction is a write |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Transaction write data |
| bus_ack | input | 1 | Memory completes the transaction |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_we | input | 1 | That transaction is a write |
| snoop_addr | input | ADDR_W | That transaction's address |

## Verification
A read hit answers one cycle after its lookup edge, and two cycles when a snoop takes the lookup slot. A bus access moves to the transfer phase one edge after grant. It completes one edge after the acknowledge, with `cpu_done` showing in the following cycle. A behavioural reference with a word-keyed map of cached data steps through these same phases at each rising edge using the sampled inputs. Every output is then compared at the next falling edge, so each result is checked in the exact cycle it is due. Directed tasks measure latency and bus use per operation. Presence, which is otherwise hidden, is judged from whether the next read reaches the bus.

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snoop_valid,
  input  logic              snoop_we,
  input  logic [ADDR_W-1:0] snoop_addr
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_RESP} st_t;

  st_t               state;
  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [DATA_W-1:0] rdata_q;

  logic [LINES-1:0]  line_v;
  logic [TAG_W-1:0]  line_tag  [LINES];
  logic [DATA_W-1:0] line_data [LINES];

  logic [IDX_W-1:0]  cpu_idx, snp_idx, req_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag, req_tag;
  logic              lookup, cpu_hit, snp_kill, req_hit, done_xfer, fill;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snoop_addr[IDX_W-1:0];
  assign snp_tag = snoop_addr[ADDR_W-1:IDX_W];
  assign req_idx = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:IDX_W];

  assign lookup    = (state == S_IDLE) && cpu_req && !snoop_valid;
  assign cpu_hit   = line_v[cpu_idx] && (line_tag[cpu_idx] == cpu_tag);
  assign req_hit   = line_v[req_idx] && (line_tag[req_idx] == req_tag);
  assign snp_kill  = snoop_valid && snoop_we && line_v[snp_idx] &&
                     (line_tag[snp_idx] == snp_tag);
  assign done_xfer = (state == S_XFER) && bus_ack;
  assign fill      = done_xfer && !req_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      rdata_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (lookup) begin
          req_we    <= cpu_we;
          req_addr  <= cpu_addr;
          req_wdata <= cpu_wdata;
          if (!cpu_we && cpu_hit) begin
            rdata_q <= line_data[cpu_idx];
            state   <= S_RESP;
          end else begin
            state   <= S_WAIT;
          end
        end
        S_WAIT: if (bus_gnt) state <= S_XFER;
        S_XFER: if (bus_ack) begin
          if (!req_we) rdata_q <= bus_rdata;
          state <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_v <= '0;
    end else begin
      if (snp_kill) line_v[snp_idx] <= 1'b0;
      if (fill)     line_v[req_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      line_tag[req_idx]  <= req_tag;
      line_data[req_idx] <= bus_rdata;
    end else if (done_xfer && req_hit) begin
      line_data[req_idx] <= req_wdata;
    end
  end

  assign bus_req   = (state == S_WAIT) || (state == S_XFER);
  assign bus_valid = (state == S_XFER);
  assign bus_we    = req_we;
  assign bus_addr  = req_addr;
  assign bus_wdata = req_wdata;
  assign cpu_busy  = bus_req;
  assign cpu_done  = (state == S_RESP);
  assign cpu_rdata = rdata_q;
endmodule

module wt_snoop_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              cpu_done,
  input logic              snoop_valid
);
  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_valid && !bus_gnt |=> bus_req && !bus_valid);
  // R9
  grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_valid && bus_gnt |=> bus_valid && bus_req);
  // R4
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_we));
  // R2
  ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ack |=> cpu_done && !bus_req);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done && !bus_req);
  // R8
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid && !bus_req && !cpu_done |=> !bus_req && !cpu_done);
  // R3
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !bus_req && !bus_valid);
endmodule

bind wt_snoop_ctrl wt_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_ack(bus_ack), .cpu_done(cpu_done), .snoop_valid(snoop_valid)
);

// File: tb/wt_snoop_ctrl_tb.sv
module wt_snoop_ctrl_tb;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int LINES = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_busy, cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_gnt, bus_valid, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          snoop_valid = 1'b0, snoop_we = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          gnt_en = 1'b1;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  assign bus_gnt = gnt_en && bus_req;

  wt_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .snoop_valid(snoop_valid), .snoop_we(snoop_we),
    .snoop_addr(snoop_addr)
  );

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hC0DE_0000 | a;
  endfunction

  logic [DW-1:0] mem [int];

  always @(posedge clk) begin
    if (bus_valid && !bus_ack && bus_we) mem[int'(bus_addr)] = bus_wdata;
    bus_ack   <= bus_valid && !bus_ack;
    bus_rdata <= mem.exists(int'(bus_addr)) ? mem[int'(bus_addr)] : pat(int'(bus_addr));
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference
  logic [DW-1:0] mcache [int];
  int            ph = 0;
  logic          m_we = 1'b0;
  int            m_addr = 0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;
  bit            m_from_bus = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0;
      mcache.delete();
    end else begin
      if (snoop_valid && snoop_we && mcache.exists(int'(snoop_addr)))
        mcache.delete(int'(snoop_addr));
      case (ph)
        0: if (cpu_req && !snoop_valid) begin
          m_we = cpu_we; m_addr = int'(cpu_addr); m_wd = cpu_wdata;
          if (!cpu_we && mcache.exists(m_addr)) begin
            m_rd = mcache[m_addr]; m_from_bus = 1'b0; ph = 3;
          end else ph = 1;
        end
        1: if (bus_gnt) ph = 2;
        2: if (bus_ack) begin
          if (!m_we) begin
            int victims[$];
            foreach (mcache[k]) if ((k % LINES) == (m_addr % LINES)) victims.push_back(k);
            foreach (victims[i]) mcache.delete(victims[i]);
            mcache[m_addr] = bus_rdata;
            m_rd = bus_rdata; m_from_bus = 1'b1;
          end else if (mcache.exists(m_addr)) begin
            mcache[m_addr] = m_wd;
          end
          ph = 3;
        end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    chk(bus_req === (ph == 1 || ph == 2), "R9 bus_req", 32'(bus_req), 32'(ph == 1 || ph == 2));
    chk(cpu_busy === (ph == 1 || ph == 2), "R9 cpu_busy", 32'(cpu_busy), 32'(ph == 1 || ph == 2));
    chk(bus_valid === (ph == 2), "R9 bus_valid", 32'(bus_valid), 32'(ph == 2));
    chk(cpu_done === (ph == 3), "R10 cpu_done", 32'(cpu_done), 32'(ph == 3));
    if (ph == 2) begin
      chk(bus_we === m_we, "R4 bus_we", 32'(bus_we), 32'(m_we));
      chk(int'(bus_addr) == m_addr, "R4 bus_addr", 32'(bus_addr), 32'(m_addr));
      if (m_we) chk(bus_wdata === m_wd, "R4 bus_wdata", bus_wdata, m_wd);
    end
    if (ph == 3 && !m_we)
      chk(cpu_rdata === m_rd, m_from_bus ? "R2 cpu_rdata" : "R3 cpu_rdata", cpu_rdata, m_rd);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic op(input bit we, input int a, input logic [DW-1:0] wd,
                    input bit snp, output int lat, output bit used,
                    output logic [DW-1:0] rd);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd;
    if (snp) begin snoop_valid = 1'b1; snoop_we = 1'b0; snoop_addr = 12'h099; end
    lat = 0; used = 1'b0;
    do begin
      @(negedge clk);
      lat++;
      if (snp && lat == 1) snoop_valid = 1'b0;
      if (bus_req) used = 1'b1;
    end while (!cpu_done);
    rd = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input bit we, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_we = we; snoop_addr = AW'(a);
    if (we) mem[a] = d;
    @(negedge clk);
    snoop_valid = 1'b0; snoop_we = 1'b0;
  endtask

  int lat;
  bit used;
  logic [DW-1:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_req && !cpu_done && !cpu_busy && !bus_valid, "R1 reset outputs",
        {28'b0, bus_req, cpu_done, cpu_busy, bus_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !cpu_done, "R1 idle after reset", {30'b0, bus_req, cpu_done}, 32'h0);

    op(1'b0, 'h010, '0, 1'b0, lat, used, rd);
    chk(used, "R1 first read goes to bus", 32'(used), 32'd1);
    chk(rd === pat('h010), "R2 miss data", rd, pat('h010));

    op(1'b0, 'h010, '0, 1'b0, lat, used, rd);
    chk(!used, "R3 hit uses no bus", 32'(used), 32'd0);
    chk(lat == 1, "R3 hit latency", 32'(lat), 32'd1);
    chk(rd === pat('h010), "R3 hit data", rd, pat('h010));

    op(1'b1, 'h010, 32'h1111_0010, 1'b0, lat, used, rd);
    chk(used, "R4 write to present line uses bus", 32'(used), 32'd1);
    op(1'b0, 'h010, '0, 1'b0, lat, used, rd);
    chk(!used && rd === 32'h1111_0010, "R5 updated copy read locally", rd, 32'h1111_0010);

    op(1'b1, 'h025, 32'h2222_0025, 1'b0, lat, used, rd);
    chk(used, "R4 write to absent line uses bus", 32'(used), 32'd1);
    op(1'b0, 'h025, '0, 1'b0, lat, used, rd);
    chk(used, "R6 no allocate on write", 32'(used), 32'd1);
    chk(rd === 32'h2222_0025, "R6 data from memory", rd, 32'h2222_0025);

    snoop(1'b1, 'h010, 32'h3333_0010);
    op(1'b0, 'h010, '0, 1'b0, lat, used, rd);
    chk(used, "R7 snooped write invalidates", 32'(used), 32'd1);
    chk(rd === 32'h3333_0010, "R7 fresh data", rd, 32'h3333_0010);

    snoop(1'b0, 'h025, '0);
    snoop(1'b1, 'h035, 32'h5555_0035);
    op(1'b0, 'h025, '0, 1'b0, lat, used, rd);
    chk(!used, "R7 snooped read and other tag keep line", 32'(used), 32'd0);

    op(1'b0, 'h025, '0, 1'b1, lat, used, rd);
    chk(lat == 2 && !used, "R8 snoop delays lookup", 32'(lat), 32'd2);

    gnt_en = 1'b0;
    fork
      op(1'b1, 'h010, 32'h4444_0010, 1'b0, lat, used, rd);
      begin
        repeat (3) @(negedge clk);
        chk(cpu_busy && bus_req && !bus_valid, "R9 held while ungranted",
            {29'b0, cpu_busy, bus_req, bus_valid}, 32'h6);
        snoop(1'b1, 'h010, 32'h5555_0010);
        repeat (2) @(negedge clk);
        gnt_en = 1'b1;
      end
    join
    op(1'b0, 'h010, '0, 1'b0, lat, used, rd);
    chk(used, "R7 invalidated while waiting", 32'(used), 32'd1);
    chk(rd === 32'h4444_0010, "R4 own write ordered after snooped write", rd, 32'h4444_0010);

    op(1'b0, 'h015, '0, 1'b0, lat, used, rd);
    op(1'b0, 'h025, '0, 1'b0, lat, used, rd);
    chk(used, "R2 conflicting tag replaced line", 32'(used), 32'd1);
    op(1'b0, 'h025, '0, 1'b0, lat, used, rd);
    chk(!used && rd === 32'h2222_0025, "R2 refilled line hits", rd, 32'h2222_0025);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule